// File: doc/BRIEF.md
# Reflection Block Cipher Core

This block encrypts or decrypts one 64-bit block under a 128-bit key, computing one round per clock. The cipher has a mirrored shape. After input whitening, five forward rounds run. A self-inverse middle layer follows, then five rounds that undo the forward steps, and finally output whitening. Because of this symmetry, decryption uses the same hardware. The two whitening keys trade places, and the core key is XORed with a fixed 64-bit tweak.

A request is presented with `in_valid`. It is taken on a rising edge where `in_ready` is high. The key halves, the block and the mode are captured on that edge, so they may change immediately afterwards. Ten clock edges later the result appears on `dout`, and `dout_done` is high for one cycle. The result then stays on `dout` until the next operation finishes. A new request may be taken in the same cycle that `dout_done` is high.

Top module: `refl_cipher`

## Requirements
- R1: While the synchronous reset `rst` is held high, every clock edge forces `in_ready` to 1, `dout_done` to 0 and `dout` to zero.
- R2: With `decrypt`=0, the result is the encryption of `din` under key k0=`key_hi`, k1=`key_lo`. The known answer for all-zero key and block is 818665aa0d02dfda. For all-zero key and block ffffffffffffffff it is 604ae6ca03c20ada. For k1 all ones with k0 and block zero it is 78a54cbe737bb7ef.
- R3: `dout_done` goes high exactly 10 rising edges after the accepting edge and stays high for exactly one cycle.
- R4: `in_ready` is low from the accepting edge until the last round edge. A request offered in that window is ignored and changes neither the timing nor the value of the result.
- R5: With `decrypt`=1 and the same key, running the block on an earlier ciphertext returns the original plaintext.
- R6: `dout` keeps its value in every cycle in which `dout_done` is low.
- R7: The output whitening key is k0 rotated right by one bit, XOR k0 shifted right by 63. With k0 all ones and k1 and the block zero, the encryption result is 9fb51935fc3df524.
- R8: `in_ready` is high whenever `dout_done` is high. If `in_valid` is held high, completions therefore follow each other every 11 cycles.
- R9: Changing `key_hi`, `key_lo`, `din` or `decrypt` after the accepting edge has no effect on the result of the operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request to start an operation |
| in_ready | output | 1 | High when idle and able to take a request |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt; captured at acceptance |
| key_hi | input | 64 | Upper key half k0 |
| key_lo | input | 64 | Lower key half k1 |
| din | input | 64 | Plaintext or ciphertext block |
| dout | output | 64 | Result block, held between completions |
| dout_done | output | 1 | One-cycle pulse when `dout` is updated |

## Verification
The embedded properties check the control behaviour on every cycle:
- acceptance makes the core busy;
- the round counter steps by one and never passes ten;
- the final round is followed by a single-cycle completion pulse;
- the result register changes only at a completion;
- the core is always ready while the completion pulse is high.

The cipher values themselves can only be shown by the bench scenarios. These cover the known-answer vectors, the decrypt-after-encrypt round trips under several keys, and requests offered while busy. They also cover inputs scrambled right after acceptance and back-to-back operations under a held request. Each of these is compared against a behavioural model on every clock.

// File: rtl/refl_pkg.sv
package refl_pkg;

    parameter int BLK_W   = 64;
    parameter int NIB_W   = 4;
    parameter int NIBS    = BLK_W / NIB_W;
    parameter int CHUNK_W = 16;
    parameter int CHUNKS  = BLK_W / CHUNK_W;
    parameter int LANES   = CHUNK_W / NIB_W;
    parameter int ROUNDS  = 10;
    parameter int HALF    = ROUNDS / 2;
    parameter int CNT_W   = $clog2(ROUNDS + 2);

    parameter logic [BLK_W-1:0] DEC_TWEAK = 64'hc0ac29b7c97c50dd;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        blk_t k_pre;   // whitening before the first round
        blk_t k_post;  // whitening after the last round
        blk_t k_core;  // key added in every round
    } keyset_t;

    function automatic blk_t round_const(input cnt_t idx);
        blk_t rc;
        case (int'(idx))
            0:       rc = 64'h0000000000000000;
            1:       rc = 64'h13198a2e03707344;
            2:       rc = 64'ha4093822299f31d0;
            3:       rc = 64'h082efa98ec4e6c89;
            4:       rc = 64'h452821e638d01377;
            5:       rc = 64'hbe5466cf34e90c6c;
            6:       rc = 64'h7ef84f78fd955cb1;
            7:       rc = 64'h85840851f1ac43aa;
            8:       rc = 64'hc882d32f25323c54;
            9:       rc = 64'h64a51195e0e3610d;
            10:      rc = 64'hd3b5a399ca0c2399;
            11:      rc = 64'hc0ac29b7c97c50dd;
            default: rc = '0;
        endcase
        return rc;
    endfunction

    function automatic nib_t sbox_fwd(input nib_t x);
        nib_t y;
        case (x)
            4'h0: y = 4'hB;  4'h1: y = 4'hF;  4'h2: y = 4'h3;  4'h3: y = 4'h2;
            4'h4: y = 4'hA;  4'h5: y = 4'hC;  4'h6: y = 4'h9;  4'h7: y = 4'h1;
            4'h8: y = 4'h6;  4'h9: y = 4'h7;  4'hA: y = 4'h8;  4'hB: y = 4'h0;
            4'hC: y = 4'hE;  4'hD: y = 4'h5;  4'hE: y = 4'hD;  default: y = 4'h4;
        endcase
        return y;
    endfunction

    // Inverse substitution found by searching the forward table.
    function automatic nib_t sbox_inv(input nib_t y);
        nib_t r;
        r = '0;
        for (int v = 0; v < (1 << NIB_W); v++) begin
            if (sbox_fwd(nib_t'(v)) == y) r = nib_t'(v);
        end
        return r;
    endfunction

    // Self-inverse linear layer. Bit positions are counted from the MSB.
    // Output nibble j, bit b of a chunk is the XOR of bit b of the three input
    // nibbles i with (i + j + h) mod 4 != b. h is 0 for the outer chunks and
    // 1 for the inner chunks.
    function automatic blk_t mix_layer(input blk_t x);
        blk_t y;
        int   h;
        y = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            h = (c == 0 || c == CHUNKS - 1) ? 0 : 1;
            for (int j = 0; j < LANES; j++) begin
                for (int b = 0; b < NIB_W; b++) begin
                    for (int i = 0; i < LANES; i++) begin
                        if (((i + j + h) % LANES) != b) begin
                            y[BLK_W-1-(c*CHUNK_W + j*NIB_W + b)] ^=
                                x[BLK_W-1-(c*CHUNK_W + i*NIB_W + b)];
                        end
                    end
                end
            end
        end
        return y;
    endfunction

    // Nibble permutation with nibbles counted from the MSB.
    // Forward: out[n] = in[n + 4*(n mod 4)]. Inverse: out[n] = in[n - 4*(n mod 4)].
    function automatic blk_t row_shift(input blk_t x, input logic inv);
        blk_t y;
        int   src;
        y = '0;
        for (int n = 0; n < NIBS; n++) begin
            if (inv) src = (n - LANES * (n % LANES) + NIBS) % NIBS;
            else     src = (n + LANES * (n % LANES)) % NIBS;
            y[BLK_W-1-NIB_W*n -: NIB_W] = x[BLK_W-1-NIB_W*src -: NIB_W];
        end
        return y;
    endfunction

endpackage

// File: rtl/refl_sbox_layer.sv
module refl_sbox_layer
    import refl_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  blk_t din,
    output blk_t dout
);

    for (genvar n = 0; n < NIBS; n++) begin : g_lane
        if (INVERSE) begin : g_inv
            assign dout[n*NIB_W +: NIB_W] = sbox_inv(din[n*NIB_W +: NIB_W]);
        end else begin : g_fwd
            assign dout[n*NIB_W +: NIB_W] = sbox_fwd(din[n*NIB_W +: NIB_W]);
        end
    end

endmodule

// File: rtl/refl_keyprep.sv
module refl_keyprep
    import refl_pkg::*;
(
    input  blk_t    key_hi,
    input  blk_t    key_lo,
    input  logic    decrypt,
    output keyset_t keys
);

    blk_t k_derived;

    // Rotate right by one, then fold the old MSB into bit 0 (R7).
    assign k_derived = {key_hi[0], key_hi[BLK_W-1:1]}
                     ^ {{(BLK_W-1){1'b0}}, key_hi[BLK_W-1]};

    always_comb begin
        if (decrypt) begin
            keys.k_pre  = k_derived;
            keys.k_post = key_hi;
            keys.k_core = key_lo ^ DEC_TWEAK;
        end else begin
            keys.k_pre  = key_hi;
            keys.k_post = k_derived;
            keys.k_core = key_lo;
        end
    end

endmodule

// File: rtl/refl_round.sv
module refl_round
    import refl_pkg::*;
(
    input  blk_t state,
    input  cnt_t rnd,
    input  blk_t k_core,
    output blk_t nxt
);

    blk_t rc;
    blk_t fwd_s, fwd_o;
    blk_t mid_s, mid_m, mid_o;
    blk_t inv_x, inv_m, inv_o;

    assign rc = round_const(rnd);

    // Forward round: substitute, mix, permute, add constant and key.
    refl_sbox_layer #(.INVERSE(1'b0)) u_fwd_sub (.din(state), .dout(fwd_s));
    assign fwd_o = row_shift(mix_layer(fwd_s), 1'b0) ^ rc ^ k_core;

    // Middle reflection, chained after the last forward round.
    refl_sbox_layer #(.INVERSE(1'b0)) u_mid_sub (.din(fwd_o), .dout(mid_s));
    assign mid_m = mix_layer(mid_s);
    refl_sbox_layer #(.INVERSE(1'b1)) u_mid_inv (.din(mid_m), .dout(mid_o));

    // Inverse round: add key and constant, unpermute, mix, inverse substitute.
    assign inv_x = state ^ k_core ^ rc;
    assign inv_m = mix_layer(row_shift(inv_x, 1'b1));
    refl_sbox_layer #(.INVERSE(1'b1)) u_inv_sub (.din(inv_m), .dout(inv_o));

    always_comb begin
        if (rnd < cnt_t'(HALF))       nxt = fwd_o;
        else if (rnd == cnt_t'(HALF)) nxt = mid_o;
        else                          nxt = inv_o;
    end

endmodule

// File: rtl/refl_ctrl.sv
module refl_ctrl
    import refl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy,
    output cnt_t rnd,
    output logic last,
    output logic done
);

    assign busy = (rnd != '0);
    assign last = (rnd == cnt_t'(ROUNDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd  <= '0;
            done <= 1'b0;
        end else begin
            done <= last;
            if (fire)      rnd <= cnt_t'(1);
            else if (last) rnd <= '0;
            else if (busy) rnd <= rnd + 1'b1;
        end
    end

    AST_FIRE_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        fire |=> (busy && rnd == cnt_t'(1)));                          // R4
    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (rnd == cnt_t'($past(rnd) + 1'b1)));        // R3
    AST_ROUND_LIMIT: assert property (@(posedge clk) disable iff (rst)
        rnd <= cnt_t'(ROUNDS));                                        // R3
    AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        last |=> (done && !busy));                                     // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R3

endmodule

// File: rtl/refl_cipher.sv
module refl_cipher
    import refl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             decrypt,
    input  logic [BLK_W-1:0] key_hi,
    input  logic [BLK_W-1:0] key_lo,
    input  logic [BLK_W-1:0] din,
    output logic [BLK_W-1:0] dout,
    output logic             dout_done
);

    keyset_t ks_in;
    blk_t    state_q, k_core_q, k_post_q, nxt;
    cnt_t    rnd;
    logic    busy, last, fire;

    assign fire     = in_valid && !busy;
    assign in_ready = !busy;

    refl_keyprep u_keyprep (
        .key_hi  (key_hi),
        .key_lo  (key_lo),
        .decrypt (decrypt),
        .keys    (ks_in)
    );

    refl_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .busy (busy),
        .rnd  (rnd),
        .last (last),
        .done (dout_done)
    );

    refl_round u_round (
        .state  (state_q),
        .rnd    (rnd),
        .k_core (k_core_q),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= '0;
            k_core_q <= '0;
            k_post_q <= '0;
            dout     <= '0;
        end else begin
            if (fire) begin
                state_q  <= din ^ ks_in.k_pre ^ ks_in.k_core ^ round_const(cnt_t'(0));
                k_core_q <= ks_in.k_core;
                k_post_q <= ks_in.k_post;
            end else if (busy) begin
                state_q <= nxt;
            end
            if (last) begin
                dout <= nxt ^ round_const(cnt_t'(ROUNDS + 1)) ^ k_core_q ^ k_post_q;
            end
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dout_done |-> $stable(dout));                                 // R6
    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        dout_done |-> in_ready);                                       // R8
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);                         // R4

endmodule

// File: tb/test_refl_cipher.sv
`timescale 1ns/1ps
module test_refl_cipher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        decrypt = 1'b0;
    logic [63:0] key_hi = '0, key_lo = '0, din = '0;
    logic [63:0] dout;
    logic        dout_done;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    bit chk_en   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    refl_cipher i_refl_cipher (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .decrypt(decrypt), .key_hi(key_hi), .key_lo(key_lo), .din(din),
        .dout(dout), .dout_done(dout_done)
    );

    // ---------------- behavioural reference ----------------
    localparam logic [63:0] SB_TAB = 64'hBF32AC916780E5D4;
    localparam logic [15:0] MT_OUT [16] = '{
        16'h0111, 16'h2220, 16'h4404, 16'h8088, 16'h1011, 16'h0222, 16'h4440, 16'h8808,
        16'h1101, 16'h2022, 16'h0444, 16'h8880, 16'h1110, 16'h2202, 16'h4044, 16'h0888};
    localparam logic [15:0] MT_IN [16] = '{
        16'h1110, 16'h2202, 16'h4044, 16'h0888, 16'h0111, 16'h2220, 16'h4404, 16'h8088,
        16'h1011, 16'h0222, 16'h4440, 16'h8808, 16'h1101, 16'h2022, 16'h0444, 16'h8880};
    localparam logic [63:0] TB_RC [12] = '{
        64'h0000000000000000, 64'h13198a2e03707344, 64'ha4093822299f31d0,
        64'h082efa98ec4e6c89, 64'h452821e638d01377, 64'hbe5466cf34e90c6c,
        64'h7ef84f78fd955cb1, 64'h85840851f1ac43aa, 64'hc882d32f25323c54,
        64'h64a51195e0e3610d, 64'hd3b5a399ca0c2399, 64'hc0ac29b7c97c50dd};

    function automatic logic [3:0] tb_sb(input logic [3:0] x);
        return SB_TAB[63 - 4*x -: 4];
    endfunction

    function automatic logic [63:0] tb_sub(input logic [63:0] x, input bit inv);
        logic [63:0] y;
        for (int n = 0; n < 16; n++) begin
            if (!inv) y[4*n +: 4] = tb_sb(x[4*n +: 4]);
            else
                for (int v = 0; v < 16; v++)
                    if (tb_sb(4'(v)) == x[4*n +: 4]) y[4*n +: 4] = 4'(v);
        end
        return y;
    endfunction

    function automatic logic [63:0] tb_mix(input logic [63:0] x);
        logic [63:0] y = '0;
        for (int ch = 0; ch < 4; ch++) begin
            logic [15:0] acc = '0;
            for (int k = 0; k < 16; k++)
                if (x[16*ch + k]) acc ^= (ch == 0 || ch == 3) ? MT_OUT[k] : MT_IN[k];
            y[16*ch +: 16] = acc;
        end
        return y;
    endfunction

    function automatic logic [63:0] tb_shift(input logic [63:0] x, input bit inv);
        logic [63:0] y = '0;
        for (int i = 0; i < 4; i++) begin
            logic [63:0] row = x & (64'hF000F000F000F000 >> (4*i));
            int sh = inv ? 16*i : 64 - 16*i;
            y |= (row >> sh) | (row << (64 - sh));
        end
        return y;
    endfunction

    function automatic logic [63:0] ref_crypt(input logic [63:0] pt, k0, k1, input bit dec);
        logic [63:0] k2 = {k0[0], k0[63:1]} ^ (k0 >> 63);
        logic [63:0] ka = dec ? k2 : k0;
        logic [63:0] kb = dec ? k0 : k2;
        logic [63:0] kc = dec ? (k1 ^ 64'hc0ac29b7c97c50dd) : k1;
        logic [63:0] st = pt ^ ka ^ kc ^ TB_RC[0];
        for (int r = 1; r <= 5; r++) st = tb_shift(tb_mix(tb_sub(st, 0)), 0) ^ TB_RC[r] ^ kc;
        st = tb_sub(tb_mix(tb_sub(st, 0)), 1);
        for (int r = 6; r <= 10; r++) st = tb_sub(tb_mix(tb_shift(st ^ kc ^ TB_RC[r], 1)), 1);
        return st ^ TB_RC[11] ^ kc ^ kb;
    endfunction

    // ---------------- cycle model ----------------
    logic        m_busy, m_done;
    int          m_cnt;
    logic [63:0] m_res, m_pend;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_busy <= 0; m_cnt <= 0; m_done <= 0; m_res <= '0;
        end else begin
            m_done <= 0;
            if (!m_busy) begin
                if (in_valid) begin
                    m_busy <= 1; m_cnt <= 1;
                    m_pend <= ref_crypt(din, key_hi, key_lo, decrypt);
                end
            end else if (m_cnt == 10) begin
                m_busy <= 0; m_cnt <= 0; m_done <= 1; m_res <= m_pend;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            check(in_ready == !m_busy, "R4 ready while busy", 64'(in_ready), 64'(!m_busy));
            check(dout_done == m_done, "R3 done timing", 64'(dout_done), 64'(m_done));
            check(dout == m_res, "R6 result register", dout, m_res);
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000) begin
            n_err++;
            $display("FAIL R3 watchdog expired: actual=%0d expected<60000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    task automatic run_op(input bit dec, input logic [63:0] khi, klo, blk,
                          output logic [63:0] res);
        int lat;
        while (!in_ready) @(negedge clk);
        decrypt = dec; key_hi = khi; key_lo = klo; din = blk; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        key_hi = ~khi; key_lo = khi ^ klo ^ 64'h5a5a_a5a5_3c3c_c3c3;
        din = ~blk; decrypt = ~dec;   // R9 scramble after acceptance
        lat = 0;
        while (!dout_done && lat < 40) begin
            in_valid = (lat % 3 == 1);   // R4 requests while busy
            din = din + 64'h1111;
            @(negedge clk);
            lat++;
        end
        in_valid = 0;
        check(lat == 10, "R3 latency", 64'(lat), 64'd10);
        res = dout;
        @(negedge clk);
        check(!dout_done, "R3 single-cycle pulse", 64'(dout_done), 64'd0);
    endtask

    task automatic vec(input logic [63:0] k0, k1, pt, ct, input string req);
        logic [63:0] r, back;
        run_op(0, k0, k1, pt, r);
        check(r == ct, req, r, ct);
        check(r == ref_crypt(pt, k0, k1, 0), "R9 result unaffected by later inputs", r, ref_crypt(pt, k0, k1, 0));
        run_op(1, k0, k1, r, back);
        check(back == pt, "R5 decrypt recovers plaintext", back, pt);
    endtask

    initial begin
        logic [63:0] seed, r, back, held;
        int d1, d2, nd;
        repeat (3) @(negedge clk);
        check(in_ready == 1, "R1 ready in reset", 64'(in_ready), 64'd1);
        check(dout_done == 0, "R1 done in reset", 64'(dout_done), 64'd0);
        check(dout == '0, "R1 result in reset", dout, 64'd0);
        rst = 0; chk_en = 1;
        @(negedge clk);

        vec(64'h0, 64'h0, 64'h0, 64'h818665aa0d02dfda, "R2 vector zero");
        vec(64'h0, 64'h0, '1, 64'h604ae6ca03c20ada, "R2 vector ones block");
        vec('1, 64'h0, 64'h0, 64'h9fb51935fc3df524, "R7 vector k0 ones");
        vec(64'h0, '1, 64'h0, 64'h78a54cbe737bb7ef, "R2 vector k1 ones");

        seed = 64'h9e3779b97f4a7c15;
        for (int t = 0; t < 6; t++) begin
            logic [63:0] k0, k1, pt;
            seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17; k0 = seed;
            seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17; k1 = seed;
            seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17; pt = seed;
            run_op(0, k0, k1, pt, r);
            check(r == ref_crypt(pt, k0, k1, 0), "R2 random encrypt", r, ref_crypt(pt, k0, k1, 0));
            run_op(1, k0, k1, r, back);
            check(back == pt, "R5 random round trip", back, pt);
        end

        // R6: result held while idle and inputs move
        held = dout;
        for (int i = 0; i < 6; i++) begin
            din = din ^ 64'hffff0000ffff0000; key_hi = key_hi + 1;
            @(negedge clk);
            check(dout == held, "R6 result held while idle", dout, held);
        end

        // R8: held request gives completions 11 cycles apart
        decrypt = 0; key_hi = 64'h0; key_lo = 64'h0; din = 64'h0; in_valid = 1;
        d1 = -1; d2 = -1; nd = 0;
        for (int i = 1; i <= 25; i++) begin
            @(negedge clk);
            if (dout_done) begin
                check(in_ready == 1, "R8 ready during done", 64'(in_ready), 64'd1);
                check(dout == 64'h818665aa0d02dfda, "R8 back-to-back result", dout, 64'h818665aa0d02dfda);
                if (nd == 0) d1 = i; else d2 = i;
                nd++;
            end
        end
        in_valid = 0;
        check(nd == 2, "R8 completions under held request", 64'(nd), 64'd2);
        check(d2 - d1 == 11, "R8 completion spacing", 64'(d2 - d1), 64'd11);
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);

        // R1: synchronous reset mid-operation
        decrypt = 0; din = 64'h1234; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        repeat (3) @(negedge clk);
        chk_en = 0; rst = 1;
        @(negedge clk);
        check(in_ready == 1, "R1 reset clears busy", 64'(in_ready), 64'd1);
        check(dout == '0, "R1 reset clears result", dout, 64'd0);
        check(dout_done == 0, "R1 reset clears done", 64'(dout_done), 64'd0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_en = 1;
        repeat (12) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule